// File: doc/BRIEF.md
# USB Port Status, Ownership and Wake Register

This block is the status and control word of one host-controller root port. It is 32 bits wide and sits on a plain register bus: a one-cycle write strobe with a data word, and a read word that always shows the current contents. Software writes three wake-enable bits, a four-bit port test selector and a port-ownership bit through this bus. The block itself samples the port's connect level and over-current level, and a global "controller configured" flag.

From those inputs it produces a single-cycle request to set the power-management event status. The request fires when an enabled wake condition occurs: a connect, a disconnect, or the onset of over-current. The configured flag overrides the ownership bit. While the flag is low, the port belongs to the companion controller. When the flag rises, ownership returns to this controller, and this rule beats any software write in the same cycle. A decoder reports whether the stored test selector is a defined test and which one.

Top module: `usb_port_wake_reg`

## Requirements
- R1: Out of reset, with the connect, over-current and configured inputs low, `rd_data` reads 32'h0000_3000, `pme_set` is 0, `test_mode_valid` is 1 and `test_code` is 0.
- R2: Bit 12 (port power) always reads 1. Every bit except 22:20, 19:16, 13, 12, 4 and 0 always reads 0, and writing ones to those bits has no effect.
- R3: A write stores `wr_data[22:20]` as the wake enables (22 over-current, 21 disconnect, 20 connect) and `wr_data[19:16]` as the test selector. Both read back on `rd_data` from the cycle after the write strobe.
- R4: When bit 20 is set and the connect input goes 0 to 1, `pme_set` is high for exactly one cycle. That cycle follows the clock edge after the one that first samples the new level.
- R5: When bit 21 is set and the connect input goes 1 to 0, `pme_set` pulses for one cycle with the same timing as R4.
- R6: When bit 22 is set, `pme_set` pulses once on the 0-to-1 change of over-current, with the same timing as R4. It does not pulse again while over-current stays high, and it does not pulse when over-current goes low.
- R7: An edge whose enable bit is 0 gives no pulse. Several enabled conditions in the same cycle give one single-cycle pulse.
- R8: Bit 0 reads the connect level and bit 4 reads the over-current level, one clock edge after the input changes.
- R9: While `cfg_flag` is 0, bit 13 (port owner) reads 1 from the next cycle, and writes to it are ignored.
- R10: On a 0-to-1 change of `cfg_flag`, bit 13 becomes 0, even if the same cycle writes a 1 to it.
- R11: While `cfg_flag` stays 1, a write sets bit 13 to `wr_data[13]`.
- R12: Test selector values 0 to 5 give `test_mode_valid` = 1 and `test_code` = the value (0 normal, 1 J, 2 K, 3 SE0/NAK, 4 packet, 5 force enable). Values 6 to 15 are stored and read back, but give `test_mode_valid` = 0 and `test_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| conn_sts | input | 1 | Port connect level |
| ovc_active | input | 1 | Port over-current level |
| cfg_flag | input | 1 | Global configured flag |
| pme_set | output | 1 | One-cycle request to set power-management event status |
| test_mode_valid | output | 1 | Stored test selector is a defined value |
| test_code | output | 3 | Decoded test mode, 0 when normal or undefined |

## Verification
A wrong previous-level register shows up on `pme_set` two edges after an input change. The symptom is a missing pulse, a pulse that repeats while a level is held, or a pulse on the wrong edge. A wrong ownership state appears on bit 13 of `rd_data` one edge after a change of `cfg_flag` or a write. The bench keeps a model of every field and compares the full read word, the pulse and the decode outputs every cycle, so any diverging state shows up within at most two cycles of the stimulus that exposes it.

// File: rtl/usbpw_pkg.sv
// Shared field positions, reset word and test-mode codes for the port
// status and wake register. Assumes a 32-bit register word.
package usbpw_pkg;
    localparam int REG_W     = 32;
    localparam int CONN_BIT  = 0;
    localparam int OVC_BIT   = 4;
    localparam int PWR_BIT   = 12;
    localparam int OWN_BIT   = 13;
    localparam int TSEL_LSB  = 16;
    localparam int TSEL_W    = 4;
    localparam int WAKE_LSB  = 20;
    localparam int WAKE_W    = 3;
    localparam int TCODE_W   = 3;
    // wake enable indices within the enable field
    localparam int WK_CONN   = 0;
    localparam int WK_DISC   = 1;
    localparam int WK_OVC    = 2;
    localparam logic [REG_W-1:0] RESET_WORD = 32'h0000_3000;

    typedef enum logic [TCODE_W-1:0] {
        TM_NORMAL   = 3'd0,
        TM_J        = 3'd1,
        TM_K        = 3'd2,
        TM_SE0_NAK  = 3'd3,
        TM_PACKET   = 3'd4,
        TM_FORCE_EN = 3'd5
    } test_mode_e;

    localparam int TM_LAST = 5;
endpackage

// File: rtl/usbpw_edge_det.sv
// Registers a vector of port level inputs and flags their rising and falling
// edges. Assumes the inputs are already synchronous to clk. The registered
// level is also the readable status value.
module usbpw_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] level_q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // capture current level and the level one cycle older
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            level_q <= sig_in;
            prev_q  <= level_q;
        end
    end

    // per-bit edge flags from the two stored samples
    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = level_q[i] & ~prev_q[i];
        assign fall[i] = ~level_q[i] & prev_q[i];
    end
endmodule

// File: rtl/usbpw_owner_ctl.sv
// Port ownership bit. The configured flag is the master: low forces the
// companion to own the port, a rising edge hands it back to this controller.
// Software writes only land while the flag stays high.
module usbpw_owner_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_flag,
    input  logic wr_en,
    input  logic wr_owner,
    output logic owner
);
    logic cfg_prev;

    // remember the flag to detect its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_prev <= 1'b0;
        else        cfg_prev <= cfg_flag;
    end

    // hardware rules first, software write last
    always_ff @(posedge clk) begin
        if (!rst_n)              owner <= 1'b1;
        else if (!cfg_flag)      owner <= 1'b1;
        else if (!cfg_prev)      owner <= 1'b0;
        else if (wr_en)          owner <= wr_owner;
    end

    // R9
    owner_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flag |=> owner);
    // R10
    owner_handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_flag) |=> !owner);
endmodule

// File: rtl/usbpw_test_decode.sv
// Decodes the stored port test selector. Defined codes pass through and
// flag valid; undefined codes report normal operation with valid low.
module usbpw_test_decode
    import usbpw_pkg::*;
#(
    parameter int SEL_W = TSEL_W
) (
    input  logic [SEL_W-1:0]   sel,
    output logic               valid,
    output logic [TCODE_W-1:0] code
);
    test_mode_e mode;

    // range check then narrow the value into the mode type
    always_comb begin
        valid = (int'(sel) <= TM_LAST);
        mode  = valid ? test_mode_e'(sel[TCODE_W-1:0]) : TM_NORMAL;
        code  = mode;
    end
endmodule

// File: rtl/usb_port_wake_reg.sv
// One root-port status/control word with wake request generation.
// Assumes conn_sts, ovc_active and cfg_flag are synchronous to clk and that
// rd_data is sampled combinationally by the bus. pme_set is one cycle wide.
module usb_port_wake_reg
    import usbpw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               conn_sts,
    input  logic               ovc_active,
    input  logic               cfg_flag,
    output logic               pme_set,
    output logic               test_mode_valid,
    output logic [TCODE_W-1:0] test_code
);
    localparam int NLVL = 2;   // index 0 connect, 1 over-current

    logic [WAKE_W-1:0] wake_en;
    logic [TSEL_W-1:0] tsel;
    logic              owner;
    logic [NLVL-1:0]   lvl, lvl_rise, lvl_fall;
    logic              wake_hit;

    // level sampling and edge detection
    usbpw_edge_det #(.W(NLVL)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({ovc_active, conn_sts}),
        .level_q(lvl),
        .rise   (lvl_rise),
        .fall   (lvl_fall)
    );

    // ownership under configured-flag control
    usbpw_owner_ctl u_owner (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_flag(cfg_flag),
        .wr_en   (wr_en),
        .wr_owner(wr_data[OWN_BIT]),
        .owner   (owner)
    );

    // test selector decode
    usbpw_test_decode #(.SEL_W(TSEL_W)) u_tdec (
        .sel  (tsel),
        .valid(test_mode_valid),
        .code (test_code)
    );

    // software-writable enable and test fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en <= RESET_WORD[WAKE_LSB +: WAKE_W];
            tsel    <= RESET_WORD[TSEL_LSB +: TSEL_W];
        end else if (wr_en) begin
            wake_en <= wr_data[WAKE_LSB +: WAKE_W];
            tsel    <= wr_data[TSEL_LSB +: TSEL_W];
        end
    end

    // merge enabled wake conditions into one request
    always_comb begin
        wake_hit = (wake_en[WK_CONN] & lvl_rise[0])
                 | (wake_en[WK_DISC] & lvl_fall[0])
                 | (wake_en[WK_OVC]  & lvl_rise[1]);
    end

    // register the request as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) pme_set <= 1'b0;
        else        pme_set <= wake_hit;
    end

    // assemble the read word; unlisted bits stay zero
    always_comb begin
        rd_data                          = '0;
        rd_data[CONN_BIT]                = lvl[0];
        rd_data[OVC_BIT]                 = lvl[1];
        rd_data[PWR_BIT]                 = 1'b1;
        rd_data[OWN_BIT]                 = owner;
        rd_data[TSEL_LSB +: TSEL_W]      = tsel;
        rd_data[WAKE_LSB +: WAKE_W]      = wake_en;
    end

    // R3
    wake_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[WAKE_LSB +: WAKE_W] == $past(wr_data[WAKE_LSB +: WAKE_W]));
    // R3
    tsel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[TSEL_LSB +: TSEL_W] == $past(wr_data[TSEL_LSB +: TSEL_W]));
    // R7
    pme_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pme_set |-> $past(|rd_data[WAKE_LSB +: WAKE_W]));
endmodule

// File: tb/usb_port_wake_reg_test.sv
`timescale 1ns/100ps
module usb_port_wake_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        conn_sts = 1'b0;
    logic        ovc_active = 1'b0;
    logic        cfg_flag = 1'b0;
    logic        pme_set;
    logic        test_mode_valid;
    logic [2:0]  test_code;

    usb_port_wake_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .conn_sts(conn_sts), .ovc_active(ovc_active),
        .cfg_flag(cfg_flag), .pme_set(pme_set),
        .test_mode_valid(test_mode_valid), .test_code(test_code)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          due;
        int          sel;   // 0 rd_data, 1 pme_set, 2 valid, 3 code
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // model state, built from the requirements
    logic [2:0] m_en = '0;
    logic [3:0] m_ts = '0;
    logic       m_own = 1'b1;
    logic       m_conn = 1'b0, m_ovc = 1'b0, m_cfg = 1'b0;

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = '0;
        w[0] = m_conn; w[4] = m_ovc; w[12] = 1'b1; w[13] = m_own;
        w[19:16] = m_ts; w[22:20] = m_en;
        return w;
    endfunction

    task automatic push(int dly, int sel, logic [31:0] val, string tag);
        exp_t e;
        e.due = cyc + dly; e.sel = sel; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // driver: one call is one cycle of stimulus, expectations go to the queue
    task automatic drive(bit wr, logic [31:0] d, bit cfg, bit conn, bit ovc, string tag);
        bit c_rise, c_fall, o_rise, vld;
        @(negedge clk);
        wr_en = wr; wr_data = d; cfg_flag = cfg; conn_sts = conn; ovc_active = ovc;
        if (wr) begin
            m_en = d[22:20];
            m_ts = d[19:16];
        end
        if (!cfg)        m_own = 1'b1;
        else if (!m_cfg) m_own = 1'b0;
        else if (wr)     m_own = d[13];
        c_rise = conn & ~m_conn; c_fall = ~conn & m_conn; o_rise = ovc & ~m_ovc;
        m_cfg = cfg; m_conn = conn; m_ovc = ovc;
        vld = (m_ts <= 4'd5);
        push(1, 0, model_word(), tag);
        push(1, 2, {31'd0, vld}, tag);
        push(1, 3, vld ? {29'd0, m_ts[2:0]} : 32'd0, tag);
        push(2, 1, {31'd0, (m_en[0] & c_rise) | (m_en[1] & c_fall) | (m_en[2] & o_rise)}, tag);
    endtask

    // monitor: pop and compare everything due this cycle
    initial begin
        forever begin
            logic [31:0] act;
            @(posedge clk);
            cyc++;
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                case (e.sel)
                    0: act = rd_data;
                    1: act = {31'd0, pme_set};
                    2: act = {31'd0, test_mode_valid};
                    default: act = {29'd0, test_code};
                endcase
                checks++;
                if (act !== e.val || e.due != cyc) begin
                    errors++;
                    $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                             e.tag, e.sel, cyc, act, e.val);
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        drive(0, 32'h0, 0, 0, 0, "R1");
        drive(0, 32'h0, 0, 0, 0, "R1");
        // R2 R9 all-ones write with configured flag low
        drive(1, 32'hFFFF_FFFF, 0, 0, 0, "R2");
        drive(0, 32'h0, 0, 0, 0, "R9");
        drive(1, 32'h0000_0000, 0, 0, 0, "R9");
        // R10 flag rises together with an owner write of 1
        drive(1, 32'h0000_2000, 1, 0, 0, "R10");
        drive(0, 32'h0, 1, 0, 0, "R10");
        // R11 software control while flag steady high
        drive(1, 32'h0000_2000, 1, 0, 0, "R11");
        drive(1, 32'h0000_0000, 1, 0, 0, "R11");
        drive(1, 32'hFF80_EFEF, 1, 0, 0, "R2");
        drive(1, 32'h0000_0000, 1, 0, 0, "R2");
        // R9 flag falls, then R10 rises again
        drive(0, 32'h0, 0, 0, 0, "R9");
        drive(0, 32'h0, 1, 0, 0, "R10");
        // R12 R3 every test selector value
        for (int v = 0; v < 16; v++)
            drive(1, 32'(v) << 16, 1, 0, 0, (v <= 5) ? "R12" : "R3");
        drive(1, 32'h0000_0000, 1, 0, 0, "R12");
        // R4 R8 connect wake
        drive(1, 32'h0010_0000, 1, 0, 0, "R3");
        drive(0, 32'h0, 1, 1, 0, "R4");
        drive(0, 32'h0, 1, 1, 0, "R8");
        drive(0, 32'h0, 1, 1, 0, "R4");
        // R7 disconnect with its enable off
        drive(0, 32'h0, 1, 0, 0, "R7");
        drive(0, 32'h0, 1, 0, 0, "R7");
        // R5 disconnect wake
        drive(1, 32'h0020_0000, 1, 1, 0, "R5");
        drive(0, 32'h0, 1, 0, 0, "R5");
        drive(0, 32'h0, 1, 0, 0, "R5");
        drive(0, 32'h0, 1, 0, 0, "R5");
        // R7 connect rise with only disconnect enabled
        drive(0, 32'h0, 1, 1, 0, "R7");
        drive(0, 32'h0, 1, 1, 0, "R7");
        // R6 over-current onset, hold and release
        drive(1, 32'h0040_0000, 1, 1, 0, "R6");
        drive(0, 32'h0, 1, 1, 1, "R6");
        for (int k = 0; k < 5; k++) drive(0, 32'h0, 1, 1, 1, "R6");
        drive(0, 32'h0, 1, 1, 0, "R6");
        drive(0, 32'h0, 1, 1, 0, "R6");
        drive(0, 32'h0, 1, 1, 0, "R8");
        // R7 merge of simultaneous conditions
        drive(1, 32'h0070_0000, 1, 0, 0, "R7");
        drive(0, 32'h0, 1, 0, 0, "R7");
        drive(0, 32'h0, 1, 1, 1, "R7");
        drive(0, 32'h0, 1, 1, 1, "R7");
        drive(0, 32'h0, 1, 1, 1, "R7");
        drive(0, 32'h0, 1, 0, 1, "R5");
        drive(0, 32'h0, 1, 0, 1, "R5");
        drive(0, 32'h0, 1, 0, 0, "R6");
        drive(0, 32'h0, 1, 0, 0, "R6");
        drive(0, 32'h0, 1, 0, 0, "R6");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #50000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule